// File: doc/BRIEF.md
# Dynamic Genlock Frame Pointer Controller

This block decides which frame store a video writer channel and a video reader channel use when both work on one circular set of buffers. The writer leads and the reader follows. On each of its frame starts, the writer steps to the next buffer in circular order. If that buffer is the one the reader holds, the writer skips over it. On each of its frame starts, the reader takes the buffer the writer most recently finished. Each side shows its current buffer on a Gray-coded pointer, so that a controller in another clock domain can sample the pointer safely.

The peer pointers can come from inside the block or from external input pins. Internal routing links the two channels directly. External routing passes each incoming Gray pointer through a two-flop synchronizer and decodes it to binary before use. When genlock is off, each channel steps through its buffers on its own. The buffer count can be changed at run time. Values outside 2 to the maximum are clamped.

Top module: `genlock_ptr_ctrl`

## Requirements
- R1: After reset, `wr_buf_idx`, `rd_buf_idx`, `wr_ptr_gray` and `rd_ptr_gray` are all 0.
- R2: With `genlock_en` low, each channel moves from index i to (i+1) mod N on each of its own frame starts, where N is the clamped buffer count.
- R3: A buffer index changes only in the cycle after its own channel's frame-start strobe. It is stable otherwise.
- R4: With `genlock_en` high, the writer's candidate is (i+1) mod N. If the candidate equals the reader buffer it must avoid, the writer takes (i+2) mod N instead. In internal mode, the buffer to avoid is the reader's current index. If the reader also starts a frame in that cycle, it is the reader's new index instead.
- R5: With `genlock_en` high in internal mode, a reader frame start loads the index the writer held at its most recent `wr_frame_done` strobe. The value used is the one registered before that cycle.
- R6: With `genlock_en` high, a reader frame start leaves `rd_buf_idx` unchanged until the writer has completed at least one frame since reset.
- R7: Each pointer output is the Gray code of its index: g = b XOR (b >> 1).
- R8: `num_bufs` values below 2 act as 2, and values above 8 act as 8.
- R9: With `ptr_src_int` low, both peer inputs are used instead of internal routing. The writer avoids the binary value of `wr_peer_gray_in`, sampled through two flops. The reader tracks `rd_peer_gray_in`, sampled through two flops. Each time the synchronized reader-side value changes, the value it changed from becomes the reader's completed buffer and marks that a frame is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| genlock_en | input | 1 | 1 = writer/reader coordination active |
| ptr_src_int | input | 1 | 1 = internal pointer routing, 0 = use peer input pins |
| num_bufs | input | 4 | Buffer count, clamped to 2..8 |
| wr_frame_start | input | 1 | Writer frame-start strobe |
| wr_frame_done | input | 1 | Writer frame-done strobe |
| rd_frame_start | input | 1 | Reader frame-start strobe |
| wr_peer_gray_in | input | 3 | External Gray pointer of the reader, sampled by the writer |
| rd_peer_gray_in | input | 3 | External Gray pointer of the writer, sampled by the reader |
| wr_ptr_gray | output | 3 | Writer buffer index, Gray coded |
| rd_ptr_gray | output | 3 | Reader buffer index, Gray coded |
| wr_buf_idx | output | 3 | Writer buffer index, binary |
| rd_buf_idx | output | 3 | Reader buffer index, binary |

## Verification
The bench sweeps every buffer count from 2 to 8 under a mixed strobe pattern. The pattern includes writer and reader starts in the same cycle, which a design that compared against the reader's stale index would fail by landing the writer on the buffer the reader has just taken. With two buffers, a wrong skip step would make the writer stop alternating or stall it on the reader's buffer. A reader frame start before any writer completion catches a design that reads an unfinished buffer. Clamp values 0, 1 and 15 catch wrap logic that divides by a bad count. External mode checks the two-flop latency and the "previous value" rule on the reader side.

// File: rtl/genlock_pkg.sv
package genlock_pkg;
  parameter int GL_MAX_BUFS = 8;
  localparam int GL_IDX_W = $clog2(GL_MAX_BUFS);
  localparam int GL_CNT_W = GL_IDX_W + 1;
  typedef logic [GL_IDX_W-1:0] gl_idx_t;
  typedef logic [GL_CNT_W-1:0] gl_cnt_t;

  function automatic gl_idx_t gl_bin2gray(gl_idx_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic gl_idx_t gl_gray2bin(gl_idx_t g);
    gl_idx_t b;
    b[GL_IDX_W-1] = g[GL_IDX_W-1];
    for (int i = GL_IDX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // circular step; any index at or beyond the count folds to 0
  function automatic gl_idx_t gl_step(gl_idx_t x, gl_cnt_t n);
    gl_cnt_t t;
    t = {1'b0, x} + gl_cnt_t'(1);
    return (t >= n) ? gl_idx_t'(0) : t[GL_IDX_W-1:0];
  endfunction
endpackage

// File: rtl/gl_sync.sv
module gl_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[i] <= 1'b0;
          q[i]       <= 1'b0;
        end else begin
          stage_q[i] <= d[i];
          q[i]       <= stage_q[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gl_master.sv
module gl_master
  import genlock_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    start,
  input  logic    done,
  input  gl_cnt_t nbuf,
  input  gl_idx_t avoid_idx,
  output gl_idx_t idx,
  output gl_idx_t last_done,
  output logic    done_seen
);
  gl_idx_t cand1, cand2, idx_d;

  always_comb begin
    cand1 = gl_step(idx, nbuf);
    cand2 = gl_step(cand1, nbuf);
    idx_d = (en && (cand1 == avoid_idx)) ? cand2 : cand1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (start) idx <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_done <= '0;
      done_seen <= 1'b0;
    end else if (done) begin
      last_done <= idx;
      done_seen <= 1'b1;
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(idx)); // R3
endmodule

// File: rtl/gl_slave.sv
module gl_slave
  import genlock_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    start,
  input  gl_cnt_t nbuf,
  input  gl_idx_t ref_done,
  input  logic    ref_valid,
  output gl_idx_t idx,
  output gl_idx_t idx_d
);
  always_comb begin
    if (!en)            idx_d = gl_step(idx, nbuf);
    else if (ref_valid) idx_d = ref_done;
    else                idx_d = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (start) idx <= idx_d;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(idx)); // R3
  AST_RD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ref_valid && start) |=> $stable(idx)); // R6
endmodule

// File: rtl/genlock_ptr_ctrl.sv
module genlock_ptr_ctrl
  import genlock_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                genlock_en,
  input  logic                ptr_src_int,
  input  logic [GL_IDX_W:0]   num_bufs,
  input  logic                wr_frame_start,
  input  logic                wr_frame_done,
  input  logic                rd_frame_start,
  input  logic [GL_IDX_W-1:0] wr_peer_gray_in,
  input  logic [GL_IDX_W-1:0] rd_peer_gray_in,
  output logic [GL_IDX_W-1:0] wr_ptr_gray,
  output logic [GL_IDX_W-1:0] rd_ptr_gray,
  output logic [GL_IDX_W-1:0] wr_buf_idx,
  output logic [GL_IDX_W-1:0] rd_buf_idx
);
  localparam gl_cnt_t MIN_N = gl_cnt_t'(2);
  localparam gl_cnt_t MAX_N = gl_cnt_t'(GL_MAX_BUFS);

  gl_cnt_t nbuf;
  gl_idx_t wr_sync_g, rd_sync_g, rd_sync_b;
  gl_idx_t wr_avoid, rd_nxt, wr_last_done;
  logic    wr_done_seen;
  gl_idx_t seen_q, seen_d, ext_done_q, ext_done_d;
  logic    ext_valid_q, ext_valid_d, ext_chg;
  gl_idx_t rd_ref;
  logic    rd_ref_ok;

  always_comb begin
    if (num_bufs < MIN_N)      nbuf = MIN_N;
    else if (num_bufs > MAX_N) nbuf = MAX_N;
    else                       nbuf = num_bufs;
  end

  gl_sync #(.W(GL_IDX_W)) u_sync_wr (.clk(clk), .rst_n(rst_n), .d(wr_peer_gray_in), .q(wr_sync_g));
  gl_sync #(.W(GL_IDX_W)) u_sync_rd (.clk(clk), .rst_n(rst_n), .d(rd_peer_gray_in), .q(rd_sync_g));

  // external reader-side tracker: a change of the writer pointer marks completion of the old value
  always_comb begin
    rd_sync_b   = gl_gray2bin(rd_sync_g);
    ext_chg     = (rd_sync_b != seen_q);
    seen_d      = rd_sync_b;
    ext_done_d  = seen_q;
    ext_valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= '0;
      ext_done_q  <= '0;
      ext_valid_q <= 1'b0;
    end else if (ext_chg) begin
      seen_q      <= seen_d;
      ext_done_q  <= ext_done_d;
      ext_valid_q <= ext_valid_d;
    end
  end

  always_comb begin
    if (ptr_src_int) begin
      wr_avoid  = rd_frame_start ? rd_nxt : rd_buf_idx;
      rd_ref    = wr_last_done;
      rd_ref_ok = wr_done_seen;
    end else begin
      wr_avoid  = gl_gray2bin(wr_sync_g);
      rd_ref    = ext_done_q;
      rd_ref_ok = ext_valid_q;
    end
  end

  gl_master u_master (
    .clk(clk), .rst_n(rst_n), .en(genlock_en), .start(wr_frame_start),
    .done(wr_frame_done), .nbuf(nbuf), .avoid_idx(wr_avoid),
    .idx(wr_buf_idx), .last_done(wr_last_done), .done_seen(wr_done_seen));

  gl_slave u_slave (
    .clk(clk), .rst_n(rst_n), .en(genlock_en), .start(rd_frame_start),
    .nbuf(nbuf), .ref_done(rd_ref), .ref_valid(rd_ref_ok),
    .idx(rd_buf_idx), .idx_d(rd_nxt));

  assign wr_ptr_gray = gl_bin2gray(wr_buf_idx);
  assign rd_ptr_gray = gl_bin2gray(rd_buf_idx);

  AST_WR_AVOIDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (genlock_en && ptr_src_int && wr_frame_start) |=> (wr_buf_idx != rd_buf_idx)); // R4
  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!genlock_en && wr_frame_start && (wr_buf_idx == '0)) |=> ($countones(wr_ptr_gray) <= 1)); // R7
endmodule

// File: tb/sim_genlock_ptr_ctrl.sv
`timescale 1ns/1ps
module sim_genlock_ptr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, src = 1'b1;
  logic [3:0] nb = 4'd4;
  logic ms = 1'b0, md = 1'b0, ss = 1'b0;
  logic [2:0] wpeer = '0, rpeer = '0;
  logic [2:0] wg, rg, wi, ri;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  genlock_ptr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .genlock_en(en), .ptr_src_int(src), .num_bufs(nb),
    .wr_frame_start(ms), .wr_frame_done(md), .rd_frame_start(ss),
    .wr_peer_gray_in(wpeer), .rd_peer_gray_in(rpeer),
    .wr_ptr_gray(wg), .rd_ptr_gray(rg), .wr_buf_idx(wi), .rd_buf_idx(ri));

  function automatic logic [2:0] gray(logic [2:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle of strobes at a falling edge, observe at the next falling edge
  task automatic cyc(logic a, logic b, logic c);
    ms = a; md = b; ss = c;
    @(negedge clk);
    ms = 0; md = 0; ss = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // bench reference state
  int m, s, ld, n;
  bit vld;

  initial begin
    @(negedge clk);
    do_reset();
    chk(wi == 0 && ri == 0, "R1 idx", wi * 8 + ri, 0);
    chk(wg == 0 && rg == 0, "R1 gray", wg * 8 + rg, 0);

    // R2/R4/R5/R6/R7 sweeps over all counts, genlock off then on
    for (int e = 0; e < 2; e++) begin
      for (int cnt = 2; cnt <= 8; cnt++) begin
        en = e[0]; src = 1; nb = 4'(cnt); n = cnt;
        do_reset();
        m = 0; s = 0; ld = 0; vld = 0;
        for (int t = 0; t < 60; t++) begin
          bit a, b, c;
          int sn, av, c1, mn;
          a = (t % 3 == 0); b = (t % 3 == 2); c = (t % 7 == 3) || (t % 11 == 0);
          sn = s;
          if (c) sn = en ? (vld ? ld : s) : (s + 1) % n;
          av = c ? sn : s;
          mn = m;
          if (a) begin
            c1 = (m + 1) % n;
            mn = (en && c1 == av) ? (c1 + 1) % n : c1;
          end
          if (b) begin ld = m; vld = 1; end
          m = mn; s = sn;
          cyc(a, b, c);
          chk(wi == 3'(m), en ? "R4 writer" : "R2 writer", wi, m);
          chk(ri == 3'(s), en ? (vld ? "R5 reader" : "R6 reader") : "R2 reader", ri, s);
          chk(wg == gray(3'(m)) && rg == gray(3'(s)), "R7 gray", wg * 8 + rg,
              gray(3'(m)) * 8 + gray(3'(s)));
        end
      end
    end

    // R6 directed: reader start before any writer completion
    en = 1; src = 1; nb = 4'd4;
    do_reset();
    cyc(1, 0, 0);
    cyc(0, 0, 1);
    chk(ri == 0, "R6 no done yet", ri, 0);
    // R3: no strobe, nothing moves
    repeat (3) cyc(0, 0, 0);
    chk(wi == 1 && ri == 0, "R3 stable", wi * 8 + ri, 8);

    // R8 clamping
    en = 0;
    nb = 4'd0; do_reset();
    cyc(1, 0, 1); cyc(1, 0, 1);
    chk(wi == 0 && ri == 0, "R8 low clamp", wi * 8 + ri, 0);
    nb = 4'd1; do_reset();
    cyc(1, 0, 0);
    chk(wi == 1, "R8 one clamp", wi, 1);
    nb = 4'd15; do_reset();
    for (int k = 0; k < 8; k++) cyc(1, 0, 0);
    chk(wi == 0, "R8 high clamp wrap", wi, 0);
    cyc(1, 0, 0);
    chk(wi == 1, "R8 high clamp step", wi, 1);

    // R9 external routing
    en = 1; src = 0; nb = 4'd4;
    do_reset();
    wpeer = gray(3'd1);
    repeat (3) cyc(0, 0, 0);
    cyc(1, 0, 0);
    chk(wi == 2, "R9 writer skip ext", wi, 2);
    cyc(0, 0, 1);
    chk(ri == 0, "R9 reader waits", ri, 0);
    rpeer = gray(3'd3);
    repeat (4) cyc(0, 0, 0);
    cyc(0, 0, 1);
    chk(ri == 0, "R9 reader prev0", ri, 0);
    rpeer = gray(3'd2);
    repeat (4) cyc(0, 0, 0);
    cyc(0, 0, 1);
    chk(ri == 3, "R9 reader prev3", ri, 3);
    chk(rg == gray(3'd3), "R7 ext gray", rg, gray(3'd3));

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule